// File: doc/BRIEF.md
# Half-Bridge Alternating Drive Sequencer

This block takes one fixed-frequency PWM pulse stream and turns it into the three logic-level drive signals of a half-bridge converter. Successive PWM on-pulses are steered in turn to the low-side primary output and the high-side primary output. The first pulse after reset, or after the run enable returns, always goes to the low side, so that the high-side bootstrap capacitor charges before the high-side switch is ever turned on.

A third output carries timing for the synchronous rectifiers on the secondary side. It is a square wave whose level marks which primary slot is active. It changes state a programmable number of clock cycles before the leading edge of each primary pulse. To get this lead, the primary outputs are delayed by `LEAD_CYC` cycles relative to the internal pulse, and the secondary timing signal is not delayed. Each primary pulse is also clipped to `MAX_ON_CYC` cycles, which caps the duty cycle per output. A high-side inhibit input silences the high-side output without changing the order of the slots. Dropping the run enable stops all outputs in the same cycle.

Top module: `hbDriveSeq`

## Requirements
- R1: Successive accepted PWM pulses alternate between `lowDrive` and `highDrive`: low, high, low, high, and so on.
- R2: After reset, and after every period with `runEn` low, the first accepted pulse appears on `lowDrive`.
- R3: `lowDrive` and `highDrive` are never both 1 in the same clock cycle.
- R4: `syncOut` is 1 during a low-side slot and 0 during a high-side slot. It changes level exactly `LEAD_CYC` clock cycles before the rising edge of the primary pulse of that slot.
- R5: Each primary pulse lasts min(w, `MAX_ON_CYC`) cycles, where w is the number of consecutive rising clock edges at which `pwmIn` is sampled 1. A clipped pulse produces no further output until `pwmIn` has gone back to 0.
- R6: While `runEn` is 0, `lowDrive`, `highDrive` and `syncOut` are 0 in the same cycle, with no clock delay, and the slot order is reset.
- R7: While `hiInhibit` is 1, `highDrive` stays 0. Low-side pulses and the toggling of `syncOut` continue unchanged, and the inhibited pulse still uses up its high-side slot.
- R8: A pulse is accepted only on a 0-to-1 change of `pwmIn` while `runEn` is 1. A `pwmIn` level that is already high when `runEn` rises is ignored.
- R9: During and right after reset, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwmIn | input | 1 | Fixed-frequency PWM pulse stream |
| runEn | input | 1 | Run enable; 0 stops all drives at once |
| hiInhibit | input | 1 | 1 holds the high-side output low |
| lowDrive | output | 1 | Low-side primary drive |
| highDrive | output | 1 | High-side primary drive |
| syncOut | output | 1 | Secondary timing square wave, 1 = low-side slot |

## Verification
The bench sweeps the pulse width from a single cycle up past the clip limit, using a small lead and a small clip value. For each pulse it checks the side that was driven, the exact width, and the gap in cycles between the `syncOut` change and the primary rising edge. A design that is off by one stage in the delay line shows up as a wrong lead. A design with a broken clip counter produces a pulse one cycle too long, or a second pulse after the clip while `pwmIn` is still high.

Three further cases are covered. The enable is dropped in the middle of a live pulse: a registered gate would leave `lowDrive` high for one extra cycle. The enable comes back after a low-side pulse: a design that keeps the slot order would start on the high side. The inhibit is applied during a high slot: a design that also skips the slot would put two low pulses in a row in the wrong place, and one that gates the wrong output would silence `lowDrive`.

// File: rtl/hbDriveSeqPkg.sv
package hbDriveSeqPkg;

  // Strobes from the sequencing control to the delay datapath
  typedef struct packed {
    logic lowReq;    // internal low-side pulse, undelayed
    logic highReq;   // internal high-side pulse, undelayed
    logic flush;     // run enable is low: clear and silence
    logic gateHigh;  // high-side output inhibited
  } seqStrobe_t;

endpackage

// File: rtl/hbDriveSeqCtrl.sv
module hbDriveSeqCtrl
  import hbDriveSeqPkg::*;
#(
  parameter int MAX_ON_CYC = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwmIn,
  input  logic       runEn,
  input  logic       hiInhibit,
  output seqStrobe_t strobe,
  output logic       syncOut
);

  localparam int CNT_W = $clog2(MAX_ON_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_ON_CYC);

  logic             pwmPrev;
  logic             pulseOn;
  logic             curSide;   // 0 = low side, 1 = high side
  logic             nextSide;
  logic             syncReg;
  logic [CNT_W-1:0] onCnt;
  logic             startPulse;
  logic             endPulse;

  // Only a fresh rising level while running opens a pulse
  assign startPulse = runEn & pwmIn & ~pwmPrev;
  assign endPulse   = pulseOn & (~pwmIn | (onCnt == CNT_MAX));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwmPrev <= 1'b0;
    end else begin
      pwmPrev <= pwmIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !runEn) begin
      pulseOn  <= 1'b0;
      curSide  <= 1'b0;
      nextSide <= 1'b0;
      syncReg  <= 1'b0;
      onCnt    <= '0;
    end else if (startPulse) begin
      pulseOn  <= 1'b1;
      onCnt    <= CNT_W'(1);
      curSide  <= nextSide;
      nextSide <= ~nextSide;
      syncReg  <= ~nextSide;
    end else if (endPulse) begin
      pulseOn  <= 1'b0;
    end else if (pulseOn) begin
      onCnt    <= onCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strobe.lowReq   = pulseOn & ~curSide;
    strobe.highReq  = pulseOn & curSide;
    strobe.flush    = ~runEn;
    strobe.gateHigh = hiInhibit;
  end

  assign syncOut = syncReg & runEn;

endmodule

// File: rtl/hbDriveSeqPath.sv
module hbDriveSeqPath
  import hbDriveSeqPkg::*;
#(
  parameter int LEAD_CYC = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  output logic       lowDrive,
  output logic       highDrive
);

  logic lowTap;
  logic highTap;

  generate
    if (LEAD_CYC == 1) begin : g_single
      logic lowStage;
      logic highStage;
      always_ff @(posedge clk) begin
        if (!rstN || strobe.flush) begin
          lowStage  <= 1'b0;
          highStage <= 1'b0;
        end else begin
          lowStage  <= strobe.lowReq;
          highStage <= strobe.highReq;
        end
      end
      assign lowTap  = lowStage;
      assign highTap = highStage;
    end else begin : g_chain
      logic [LEAD_CYC-1:0] lowLine;
      logic [LEAD_CYC-1:0] highLine;
      always_ff @(posedge clk) begin
        if (!rstN || strobe.flush) begin
          lowLine  <= '0;
          highLine <= '0;
        end else begin
          lowLine  <= {lowLine[LEAD_CYC-2:0], strobe.lowReq};
          highLine <= {highLine[LEAD_CYC-2:0], strobe.highReq};
        end
      end
      assign lowTap  = lowLine[LEAD_CYC-1];
      assign highTap = highLine[LEAD_CYC-1];
    end
  endgenerate

  // Enable and inhibit act without a clock delay
  assign lowDrive  = lowTap & ~strobe.flush;
  assign highDrive = highTap & ~strobe.flush & ~strobe.gateHigh;

endmodule

// File: rtl/hbDriveSeq.sv
module hbDriveSeq
  import hbDriveSeqPkg::*;
#(
  parameter int LEAD_CYC   = 8,
  parameter int MAX_ON_CYC = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwmIn,
  input  logic runEn,
  input  logic hiInhibit,
  output logic lowDrive,
  output logic highDrive,
  output logic syncOut
);

  seqStrobe_t strobe;

  hbDriveSeqCtrl #(
    .MAX_ON_CYC(MAX_ON_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pwmIn    (pwmIn),
    .runEn    (runEn),
    .hiInhibit(hiInhibit),
    .strobe   (strobe),
    .syncOut  (syncOut)
  );

  hbDriveSeqPath #(
    .LEAD_CYC(LEAD_CYC)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .lowDrive (lowDrive),
    .highDrive(highDrive)
  );

endmodule

// File: rtl/hbDriveSeqChk.sv
module hbDriveSeqChk #(
  parameter int MAX_ON_CYC = 10
) (
  input logic clk,
  input logic rstN,
  input logic lowDrive,
  input logic highDrive,
  input logic syncOut
);

  localparam int RUN_W = $clog2(MAX_ON_CYC + 2);

  logic [RUN_W-1:0] driveRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      driveRun <= '0;
    end else if (lowDrive || highDrive) begin
      if (driveRun <= RUN_W'(MAX_ON_CYC)) driveRun <= driveRun + RUN_W'(1);
    end else begin
      driveRun <= '0;
    end
  end

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(lowDrive && highDrive));

  // R4
  low_sync_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lowDrive) |-> syncOut);

  // R4
  high_sync_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(highDrive) |-> !syncOut);

  // R4
  sync_leads_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncOut) |-> !lowDrive);

  // R5
  max_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lowDrive || highDrive) |-> (driveRun < RUN_W'(MAX_ON_CYC)));

endmodule

bind hbDriveSeq hbDriveSeqChk #(.MAX_ON_CYC(MAX_ON_CYC)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .lowDrive (lowDrive),
  .highDrive(highDrive),
  .syncOut  (syncOut)
);

// File: tb/test_hbDriveSeq.sv
`timescale 1ns/1ps
module test_hbDriveSeq;

  localparam int LEAD = 3;
  localparam int MAXON = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwmIn = 1'b0;
  logic runEn = 1'b0;
  logic hiInhibit = 1'b0;
  logic lowDrive, highDrive, syncOut;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int syncEdgeCyc = 0;
  int riseCyc = 0;
  int curW = 0;
  int lastW = 0;
  int dlPulses = 0;
  int dhPulses = 0;
  int overlaps = 0;
  logic prevDl = 1'b0, prevDh = 1'b0, prevSync = 1'b0;

  always #4 clk = ~clk;

  hbDriveSeq #(.LEAD_CYC(LEAD), .MAX_ON_CYC(MAXON)) i_hbDriveSeq (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .runEn(runEn),
    .hiInhibit(hiInhibit), .lowDrive(lowDrive), .highDrive(highDrive),
    .syncOut(syncOut)
  );

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (syncOut !== prevSync) syncEdgeCyc = cyc;
    if (lowDrive && !prevDl) begin riseCyc = cyc; dlPulses++; curW = 0; end
    if (highDrive && !prevDh) begin riseCyc = cyc; dhPulses++; curW = 0; end
    if (lowDrive || highDrive) curW++;
    else if (prevDl || prevDh) lastW = curW;
    if (lowDrive && highDrive) overlaps++;
    prevDl = lowDrive; prevDh = highDrive; prevSync = syncOut;
  end

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  task automatic pulse(input int w);
    @(posedge clk); #1 pwmIn = 1'b1;
    repeat (w) @(posedge clk);
    #1 pwmIn = 1'b0;
    repeat (LEAD + 3) @(posedge clk);
    @(negedge clk); #1;
  endtask

  // expSide: 0 low slot, 1 high slot
  task automatic sendCheck(input int w, input bit expSide);
    int dl0, dh0, expW;
    bit inh;
    dl0 = dlPulses; dh0 = dhPulses; inh = hiInhibit;
    expW = (w < MAXON) ? w : MAXON;
    pulse(w);
    if (!expSide) begin
      chk(dlPulses == dl0 + 1, "R1 R2 low-side pulse count", dlPulses - dl0, 1);
      chk(dhPulses == dh0, "R1 no high-side pulse in low slot", dhPulses - dh0, 0);
      chk(lastW == expW, "R5 low pulse width", lastW, expW);
      chk(riseCyc - syncEdgeCyc == LEAD, "R4 sync lead before DL", riseCyc - syncEdgeCyc, LEAD);
      chk(syncOut == 1'b1, "R4 sync level in low slot", int'(syncOut), 1);
    end else if (!inh) begin
      chk(dhPulses == dh0 + 1, "R1 high-side pulse count", dhPulses - dh0, 1);
      chk(dlPulses == dl0, "R1 no low-side pulse in high slot", dlPulses - dl0, 0);
      chk(lastW == expW, "R5 high pulse width", lastW, expW);
      chk(riseCyc - syncEdgeCyc == LEAD, "R4 sync lead before DH", riseCyc - syncEdgeCyc, LEAD);
      chk(syncOut == 1'b0, "R4 sync level in high slot", int'(syncOut), 0);
    end else begin
      chk(dhPulses == dh0, "R7 inhibited DH stays low", dhPulses - dh0, 0);
      chk(dlPulses == dl0, "R7 inhibited slot not given to DL", dlPulses - dl0, 0);
      chk(syncOut == 1'b0, "R7 sync still toggles to high slot", int'(syncOut), 0);
    end
  endtask

  task automatic finishRun();
    chk(overlaps == 0, "R3 DL and DH overlap cycles", overlaps, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int d0;
    // R9 reset state
    repeat (3) @(negedge clk);
    chk({lowDrive, highDrive, syncOut} == 3'b000, "R9 outputs in reset",
        int'({lowDrive, highDrive, syncOut}), 0);
    @(posedge clk); #1 rstN = 1'b1; runEn = 1'b1;
    repeat (3) @(negedge clk);
    chk({lowDrive, highDrive, syncOut} == 3'b000, "R9 outputs idle after reset",
        int'({lowDrive, highDrive, syncOut}), 0);

    // R1 R4 R5 width sweep across the clip limit, first slot low (R2)
    for (int w = 1; w <= MAXON + 3; w++) sendCheck(w, 1'((w - 1) % 2));

    // R7 inhibit across a low and a high slot (sweep ended after a low slot)
    hiInhibit = 1'b1;
    sendCheck(4, 1'b1);
    sendCheck(4, 1'b0);
    sendCheck(2, 1'b1);
    hiInhibit = 1'b0;
    sendCheck(3, 1'b0);

    // R6 R2 slot order reset by enable (next would be high)
    @(posedge clk); #1 runEn = 1'b0;
    @(negedge clk);
    chk(syncOut == 1'b0, "R6 sync low while disabled", int'(syncOut), 0);
    @(posedge clk); #1 runEn = 1'b1;
    sendCheck(5, 1'b0);

    // R6 drop enable during a live DL pulse (next slot high)
    @(posedge clk); #1 runEn = 1'b0; @(posedge clk); #1 runEn = 1'b1;
    @(posedge clk); #1 pwmIn = 1'b1;
    repeat (LEAD + 2) @(posedge clk);
    @(negedge clk);
    chk(lowDrive == 1'b1, "R6 DL high before drop", int'(lowDrive), 1);
    @(posedge clk); #1 runEn = 1'b0;
    @(negedge clk);
    chk({lowDrive, highDrive, syncOut} == 3'b000, "R6 outputs cleared same cycle",
        int'({lowDrive, highDrive, syncOut}), 0);

    // R8 pwm already high when enabled is ignored
    d0 = dlPulses + dhPulses;
    @(posedge clk); #1 runEn = 1'b1;
    repeat (MAXON + LEAD + 4) @(posedge clk);
    @(negedge clk); #1;
    chk(dlPulses + dhPulses == d0, "R8 held pwm at enable ignored", dlPulses + dhPulses - d0, 0);
    @(posedge clk); #1 pwmIn = 1'b0;
    repeat (LEAD + 2) @(posedge clk);
    sendCheck(2, 1'b0);
    sendCheck(1, 1'b1);

    finishRun();
  end

endmodule